// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Flags

This block shifts a 32-bit operand left logically, right logically or right arithmetically by a count taken from a register. Alongside the shifted word it produces a carry flag holding the last bit pushed out, an extend flag that always copies that carry, a negative flag, a zero flag and an overflow flag that is always cleared. Counts are reduced modulo 64, so counts equal to or beyond the word width have exact, defined results rather than wrapping around.

The shift itself is one level of combinational logic. A valid strobe captures the operand, count, shift kind and the caller's previous carry; the result and flags appear on the registered outputs on the next clock edge and stay there until the next strobe. A two-state controller tracks whether a freshly loaded result is on the outputs: `ST_IDLE` (nothing new this cycle) and `ST_LOADED` (a result was captured at the last edge). Transition `GO_LOAD` moves from either state to `ST_LOADED` whenever the strobe is high. Transition `GO_IDLE` moves from `ST_LOADED` back to `ST_IDLE` when the strobe is low. Reset enters `ST_IDLE`.

Top module: `shf_unit`

## Requirements
- R1: Only bits [5:0] of `count_i` take part; bits [7:6] have no effect on any output, so a count of 67 acts exactly like 3.
- R2: With an effective count of 0 the result equals the operand and the carry equals `carry_in_i`.
- R3: A left shift (`kind_i` = 2'b00) by 1 to 31 fills with zeros and sets carry to operand bit (32 minus count).
- R4: A logical right shift (`kind_i` = 2'b01) by 1 to 31 fills with zeros, an arithmetic right shift (`kind_i` = 2'b10) fills with copies of bit 31; both set carry to operand bit (count minus 1).
- R5: A logical shift by exactly 32 gives a zero result, with carry equal to operand bit 0 for left and bit 31 for right.
- R6: A logical shift (left or right) by 33 to 63 gives a zero result and a zero carry.
- R7: An arithmetic right shift by 32 to 63 gives all 32 bits equal to operand bit 31 and a carry equal to that bit.
- R8: The extend flag always equals the newly produced carry.
- R9: The negative flag equals result bit 31, the zero flag is 1 exactly when the result is all zeros, and the overflow flag is always 0.
- R10: Outputs change only on the clock edge where `in_valid` is high and show that operation's result after that edge; `out_valid_o` is high in the cycle after each strobe and low otherwise; all outputs are 0 after reset.
- R11: The shift-kind encoding 2'b11 behaves exactly like a logical right shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that captures a new operation |
| operand_i | input | 32 | Word to shift |
| count_i | input | 8 | Shift count, low 6 bits used |
| kind_i | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 logical right |
| carry_in_i | input | 1 | Previous carry, kept on a zero count |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Last bit shifted out |
| extend_o | output | 1 | Copy of the new carry |
| neg_o | output | 1 | Result bit 31 |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Always 0 |
| out_valid_o | output | 1 | A result was loaded at the last edge |

## Verification
A wrong count class (for example treating 32 as "above 32") shows up one cycle after the strobe as a zero carry where bit 0 or bit 31 was expected, so the operands used at the boundaries carry a 1 in those bit positions. A stuck controller state shows as `out_valid_o` high in a cycle without a preceding strobe, or outputs that move while the strobe is low; both are visible on the very next edge. Each operation is compared against a bit-at-a-time reference shift computed in the bench.

// File: rtl/shf_pkg.sv
package shf_pkg;
    typedef enum logic [1:0] {
        KIND_LSL  = 2'b00,
        KIND_LSR  = 2'b01,
        KIND_ASR  = 2'b10,
        KIND_LSR2 = 2'b11
    } shf_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } shf_state_e;

    typedef enum logic [1:0] {
        CLS_ZERO  = 2'b00,
        CLS_SHORT = 2'b01,
        CLS_WIDTH = 2'b10,
        CLS_OVER  = 2'b11
    } shf_cnt_cls_e;
endpackage

// File: rtl/shf_cnt_class.sv
module shf_cnt_class
    import shf_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_IN_W = 8,
    parameter int CNT_W    = 6
) (
    input  logic [CNT_IN_W-1:0] count_raw,
    output logic [CNT_W-1:0]    eff_cnt,
    output logic [CNT_W-1:0]    asr_cnt,
    output shf_cnt_cls_e        cls
);
    localparam logic [CNT_W-1:0] WIDTH_CNT = CNT_W'(DATA_W);

    always_comb begin
        eff_cnt = count_raw[CNT_W-1:0];
        if (eff_cnt == '0)
            cls = CLS_ZERO;
        else if (eff_cnt < WIDTH_CNT)
            cls = CLS_SHORT;
        else if (eff_cnt == WIDTH_CNT)
            cls = CLS_WIDTH;
        else
            cls = CLS_OVER;
        // arithmetic shifts saturate at the word width
        asr_cnt = (cls == CLS_OVER) ? WIDTH_CNT : eff_cnt;
    end
endmodule

// File: rtl/shf_datapath.sv
module shf_datapath
    import shf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic [DATA_W-1:0] a,
    input  logic [CNT_W-1:0]  eff_cnt,
    input  logic [CNT_W-1:0]  asr_cnt,
    input  shf_cnt_cls_e      cls,
    input  logic [1:0]        kind,
    input  logic              carry_prev,
    output logic [DATA_W-1:0] res,
    output logic              carry
);
    localparam int EXT_W = DATA_W + 1;

    logic [EXT_W-1:0]        left_ext;
    logic [EXT_W-1:0]        right_ext;
    logic signed [EXT_W-1:0] arith_ext;

    // one guard bit catches the last bit pushed out of the word
    assign left_ext  = {1'b0, a} << eff_cnt;
    assign right_ext = {a, 1'b0} >> eff_cnt;
    assign arith_ext = $signed({a, 1'b0}) >>> asr_cnt;

    always_comb begin
        res   = a;
        carry = carry_prev;
        if (cls != CLS_ZERO) begin
            unique case (kind)
                KIND_LSL: begin
                    res   = left_ext[DATA_W-1:0];
                    carry = left_ext[DATA_W];
                end
                KIND_ASR: begin
                    res   = arith_ext[DATA_W:1];
                    carry = arith_ext[0];
                end
                KIND_LSR, KIND_LSR2: begin
                    res   = right_ext[DATA_W:1];
                    carry = right_ext[0];
                end
                default: begin
                    res   = a;
                    carry = carry_prev;
                end
            endcase
        end
    end
endmodule

// File: rtl/shf_flags.sv
module shf_flags #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] res,
    output logic              neg,
    output logic              zero
);
    assign neg  = res[DATA_W-1];
    assign zero = ~|res;
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_IN_W = 8,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   operand_i,
    input  logic [CNT_IN_W-1:0] count_i,
    input  logic [1:0]          kind_i,
    input  logic                carry_in_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                carry_o,
    output logic                extend_o,
    output logic                neg_o,
    output logic                zero_o,
    output logic                ovf_o,
    output logic                out_valid_o
);
    localparam logic [CNT_W-1:0] WIDTH_CNT = CNT_W'(DATA_W);

    shf_state_e        state_q, state_d;
    logic [CNT_W-1:0]  eff_cnt, asr_cnt;
    shf_cnt_cls_e      cls;
    logic [DATA_W-1:0] res_c;
    logic              carry_c, neg_c, zero_c;

    shf_cnt_class #(.DATA_W(DATA_W), .CNT_IN_W(CNT_IN_W), .CNT_W(CNT_W)) u_cls (
        .count_raw (count_i),
        .eff_cnt   (eff_cnt),
        .asr_cnt   (asr_cnt),
        .cls       (cls)
    );

    shf_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
        .a          (operand_i),
        .eff_cnt    (eff_cnt),
        .asr_cnt    (asr_cnt),
        .cls        (cls),
        .kind       (kind_i),
        .carry_prev (carry_in_i),
        .res        (res_c),
        .carry      (carry_c)
    );

    shf_flags #(.DATA_W(DATA_W)) u_flg (
        .res  (res_c),
        .neg  (neg_c),
        .zero (zero_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid) state_d = ST_LOADED;
            ST_LOADED: if (!in_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            carry_o  <= 1'b0;
            extend_o <= 1'b0;
            neg_o    <= 1'b0;
            zero_o   <= 1'b0;
            ovf_o    <= 1'b0;
        end else if (in_valid) begin
            result_o <= res_c;
            carry_o  <= carry_c;
            extend_o <= carry_c;
            neg_o    <= neg_c;
            zero_o   <= zero_c;
            ovf_o    <= 1'b0;
        end
    end

    assign out_valid_o = (state_q == ST_LOADED);

    AST_ZERO_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && count_i[CNT_W-1:0] == '0 |=> carry_o == $past(carry_in_i) && result_o == $past(operand_i)); // R2
    AST_OVER_LOGICAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && kind_i != 2'b10 && count_i[CNT_W-1:0] > WIDTH_CNT |=> result_o == '0 && !carry_o); // R6
    AST_ASR_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && kind_i == 2'b10 && count_i[CNT_W-1:0] >= WIDTH_CNT
        |=> result_o == {DATA_W{$past(operand_i[DATA_W-1])}} && carry_o == $past(operand_i[DATA_W-1])); // R7
    AST_EXTEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> extend_o == carry_o); // R8
    AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> !(neg_o && zero_o) && !ovf_o); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result_o) && $stable(carry_o) && !out_valid_o); // R10
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid_o); // R10
endmodule

// File: tb/shf_unit_tb.sv
`timescale 1ns/1ps
module shf_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand_i = '0;
    logic [7:0]  count_i = '0;
    logic [1:0]  kind_i = '0;
    logic        carry_in_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o, extend_o, neg_o, zero_o, ovf_o, out_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shf_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand_i(operand_i),
        .count_i(count_i), .kind_i(kind_i), .carry_in_i(carry_in_i),
        .result_o(result_o), .carry_o(carry_o), .extend_o(extend_o),
        .neg_o(neg_o), .zero_o(zero_o), .ovf_o(ovf_o), .out_valid_o(out_valid_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // bit-at-a-time reference built from the requirements
    function automatic void ref_shift(input logic [31:0] a, input logic [7:0] c, input logic [1:0] k,
                                      input logic pc, output logic [31:0] r, output logic co);
        int n;
        n  = int'(c[5:0]);
        r  = a;
        co = pc;
        for (int i = 0; i < n; i++) begin
            if (k == 2'b00) begin
                co = r[31]; r = {r[30:0], 1'b0};
            end else if (k == 2'b10) begin
                co = r[0];  r = {r[31], r[31:1]};
            end else begin
                co = r[0];  r = {1'b0, r[31:1]};
            end
        end
    endfunction

    task automatic run_op(input string req, input logic [31:0] a, input logic [7:0] c,
                          input logic [1:0] k, input logic pc);
        logic [31:0] er;
        logic        ec;
        ref_shift(a, c, k, pc, er, ec);
        @(negedge clk);
        operand_i = a; count_i = c; kind_i = k; carry_in_i = pc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "result", result_o, er);
        chk(req, "carry", {31'b0, carry_o}, {31'b0, ec});
        chk("R8", "extend", {31'b0, extend_o}, {31'b0, ec});
        chk("R9", "neg", {31'b0, neg_o}, {31'b0, er[31]});
        chk("R9", "zero", {31'b0, zero_o}, {31'b0, er == 32'h0});
        chk("R9", "ovf", {31'b0, ovf_o}, 32'h0);
        chk("R10", "valid", {31'b0, out_valid_o}, 32'h1);
    endtask

    task automatic t_reset();
        chk("R10", "reset result", result_o, 32'h0);
        chk("R10", "reset carry", {31'b0, carry_o}, 32'h0);
        chk("R10", "reset valid", {31'b0, out_valid_o}, 32'h0);
    endtask

    task automatic t_zero_count();
        run_op("R2", 32'hDEAD_BEEF, 8'd0, 2'b00, 1'b1);
        run_op("R2", 32'h1234_5678, 8'd64, 2'b10, 1'b0);
        run_op("R2", 32'h8000_0001, 8'd0, 2'b01, 1'b1);
    endtask

    task automatic t_short_left();
        run_op("R3", 32'h8000_0001, 8'd1, 2'b00, 1'b0);
        run_op("R3", 32'h0001_0000, 8'd16, 2'b00, 1'b0);
        run_op("R3", 32'h0000_0003, 8'd31, 2'b00, 1'b0);
    endtask

    task automatic t_short_right();
        run_op("R4", 32'h8000_0001, 8'd1, 2'b01, 1'b0);
        run_op("R4", 32'hF000_0080, 8'd8, 2'b10, 1'b0);
        run_op("R4", 32'h7000_0080, 8'd8, 2'b10, 1'b1);
        run_op("R4", 32'hC000_0000, 8'd31, 2'b01, 1'b0);
    endtask

    task automatic t_width();
        run_op("R5", 32'h0000_0001, 8'd32, 2'b00, 1'b0);
        run_op("R5", 32'h8000_0000, 8'd32, 2'b01, 1'b0);
        run_op("R5", 32'h7FFF_FFFE, 8'd32, 2'b01, 1'b1);
    endtask

    task automatic t_over_logical();
        run_op("R6", 32'hFFFF_FFFF, 8'd33, 2'b00, 1'b1);
        run_op("R6", 32'hFFFF_FFFF, 8'd63, 2'b01, 1'b1);
    endtask

    task automatic t_arith_big();
        run_op("R7", 32'h8000_0000, 8'd32, 2'b10, 1'b0);
        run_op("R7", 32'h8123_4567, 8'd50, 2'b10, 1'b0);
        run_op("R7", 32'h7FFF_FFFF, 8'd63, 2'b10, 1'b1);
    endtask

    task automatic t_modulo();
        run_op("R1", 32'h0000_00F1, 8'd67, 2'b00, 1'b0);
        run_op("R1", 32'h8000_0010, 8'd197, 2'b10, 1'b0);
    endtask

    task automatic t_kind3();
        run_op("R11", 32'h8000_0003, 8'd2, 2'b11, 1'b0);
        run_op("R11", 32'h8000_0000, 8'd32, 2'b11, 1'b0);
    endtask

    task automatic t_hold();
        logic [31:0] keep;
        run_op("R10", 32'h0000_00A5, 8'd4, 2'b00, 1'b0);
        keep = result_o;
        @(negedge clk);
        operand_i = 32'hFFFF_FFFF; count_i = 8'd1; kind_i = 2'b01; carry_in_i = 1'b1;
        @(negedge clk);
        chk("R10", "hold result", result_o, keep);
        chk("R10", "hold valid", {31'b0, out_valid_o}, 32'h0);
        chk("R10", "hold carry", {31'b0, carry_o}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_zero_count();
        t_short_left();
        t_short_right();
        t_width();
        t_over_logical();
        t_arith_big();
        t_modulo();
        t_kind3();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule